// File: doc/BRIEF.md
# Associative Search Array with Responder Resolution

This block is a row of processing elements, each holding one record word. A single broadcast carries a key, a field mask and an operation. Every element compares its own record against the key over the bits the mask selects. The outcome lands in a small per-element stack of activity bits. The bit on top of that stack says whether the element is currently a responder. A zero on top keeps the element out of every later narrowing operation until the stack is popped or cleared.

The array reports whether any responder exists and which responder has the lowest index. It can also shrink the responder set to that single element. A minimum or maximum search over the masked field runs bit-serially from the most significant bit, one bit per cycle. It ends with exactly one responder: the lowest-indexed element that holds the extreme value. Nested searches push further levels onto the stacks, and popping returns to the enclosing set.

Top module: `assoc_array`

## Requirements
- R1: A PE hits when ((record XOR key) AND fmask) is zero. Operation code 1 (PUSH) raises stack_level by one and writes (previous responder AND hit) as the new top bit of every PE. resp_vec[i] shows the top bit of PE i.
- R2: Operation code 2 (AND) replaces each PE's top bit with (top AND hit) and leaves stack_level unchanged.
- R3: Operation code 3 (POP) lowers stack_level by one and restores the responder set that the level below held. A PUSH at level DEPTH-1 (overflow) or a POP at level 0 (underflow) leaves the stack untouched and sets stack_err. stack_err then stays at 1 until reset.
- R4: After reset the level is 0, every PE is a responder, stack_err is 0 and all records are 0. Operation code 7 (CLEAR) returns the stacks to that state but keeps stack_err.
- R5: any_resp is 1 exactly when at least one bit of resp_vec is 1.
- R6: pick_valid equals any_resp, and pick_idx is the lowest index whose resp_vec bit is 1. Operation code 6 (PICK) leaves that one PE as the only responder.
- R7: Operation codes 4 (MIN) and 5 (MAX) keep busy at 1 for exactly W cycles. The current level then holds a one-hot set: the lowest-indexed former responder whose (record AND fmask) is the smallest (MIN) or largest (MAX). An empty responder set stays empty.
- R8: An operation presented while busy is 1 is ignored.
- R9: A record load (ld_en, ld_idx, ld_data) that falls in the same cycle as a search is not seen by that search. The search compares the old record, and the next operation sees the new one.
- R10: No operation other than POP or CLEAR turns a non-responder into a responder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write ld_data into the record of PE ld_idx |
| ld_idx | input | IW | Target PE of a record load |
| ld_data | input | W | Record value to load |
| op_valid | input | 1 | Broadcast operation present |
| op_code | input | 3 | Operation: 0 none, 1 PUSH, 2 AND, 3 POP, 4 MIN, 5 MAX, 6 PICK, 7 CLEAR |
| key | input | W | Broadcast search key |
| fmask | input | W | Field mask for search and min/max |
| resp_vec | output | N | Top-of-stack bit of each PE |
| any_resp | output | 1 | At least one responder |
| pick_valid | output | 1 | pick_idx is meaningful |
| pick_idx | output | IW | Lowest-indexed responder |
| busy | output | 1 | Min/max reduction running |
| stack_level | output | LW | Current stack level |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Two functions can fall in the same cycle: a record load and a broadcast search. The bench writes a fresh value into one PE in the same cycle as an AND whose key equals that fresh value. The result must reflect the old record only. A second AND with the same key must then pick up the new record. A reduction can also overlap a newly presented operation. The bench issues a PUSH while a minimum search is still running and expects the stack level and the reduction result to show no trace of the PUSH.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  localparam int MAXW = 64;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_AND   = 3'd2,
    OP_POP   = 3'd3,
    OP_MIN   = 3'd4,
    OP_MAX   = 3'd5,
    OP_PICK  = 3'd6,
    OP_CLEAR = 3'd7
  } assoc_op_e;

  // masked equality of a record against the broadcast key
  function automatic logic f_key_hit(input logic [MAXW-1:0] rec,
                                     input logic [MAXW-1:0] key,
                                     input logic [MAXW-1:0] fmask);
    return ((rec ^ key) & fmask) == '0;
  endfunction

endpackage

// File: rtl/assoc_pe.sv
module assoc_pe #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_data,
  input  logic [W-1:0]  key,
  input  logic [W-1:0]  fmask,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lvl,
  input  logic          wr_bit,
  input  logic [LW-1:0] rd_lvl,
  output logic [W-1:0]  rec_o,
  output logic          hit_o,
  output logic          top_o
);
  import assoc_pkg::*;

  localparam logic [DEPTH-1:0] STK_BASE = DEPTH'(1);

  logic [W-1:0]     rec_q;
  logic [DEPTH-1:0] stk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
      stk_q <= STK_BASE;
    end else begin
      if (ld_en) rec_q <= ld_data;
      if (clr)        stk_q <= STK_BASE;
      else if (wr_en) stk_q[wr_lvl] <= wr_bit;
    end
  end

  assign rec_o = rec_q;
  assign top_o = stk_q[rd_lvl];
  assign hit_o = f_key_hit(MAXW'(rec_q), MAXW'(key), MAXW'(fmask));

endmodule

// File: rtl/assoc_resolve.sv
module assoc_resolve #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  resp,
  output logic          any_o,
  output logic [IW-1:0] first_idx,
  output logic [N-1:0]  first_oh
);

  function automatic logic [IW-1:0] f_lowest_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  // isolate lowest set bit
  function automatic logic [N-1:0] f_lowest_oh(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  assign any_o     = |resp;
  assign first_idx = f_lowest_idx(resp);
  assign first_oh  = f_lowest_oh(resp);

endmodule

// File: rtl/assoc_minmax.sv
module assoc_minmax #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int IW = 4,
  parameter int BW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           want_max,
  input  logic [W-1:0]   fmask,
  input  logic [N-1:0]   seed,
  input  logic [N*W-1:0] recs_flat,
  output logic           busy,
  output logic           done,
  output logic [N-1:0]   win_oh
);

  logic          busy_q, want_q;
  logic [BW-1:0] bidx_q;
  logic [W-1:0]  mask_q;
  logic [N-1:0]  cand_q, cand_n, col, hit;
  logic          keep;
  logic          win_any;
  logic [IW-1:0] win_idx;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      col[i] = recs_flat[i*W + int'(bidx_q)];
    end
  end

  assign hit    = cand_q & (want_q ? col : ~col);
  assign keep   = mask_q[bidx_q] && (hit != '0);
  assign cand_n = keep ? hit : cand_q;
  assign done   = busy_q && (bidx_q == '0);
  assign busy   = busy_q;

  // tie break: lowest index among survivors
  assoc_resolve #(.N(N), .IW(IW)) u_tie (
    .resp      (cand_n),
    .any_o     (win_any),
    .first_idx (win_idx),
    .first_oh  (win_oh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      want_q <= 1'b0;
      bidx_q <= '0;
      mask_q <= '0;
      cand_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      want_q <= want_max;
      bidx_q <= BW'(W - 1);
      mask_q <= fmask;
      cand_q <= seed;
    end else if (busy_q) begin
      cand_q <= cand_n;
      if (bidx_q == '0) busy_q <= 1'b0;
      else              bidx_q <= bidx_q - BW'(1);
    end
  end

endmodule

// File: rtl/assoc_array.sv
module assoc_array #(
  parameter int N     = 16,
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [W-1:0]  key,
  input  logic [W-1:0]  fmask,
  output logic [N-1:0]  resp_vec,
  output logic          any_resp,
  output logic          pick_valid,
  output logic [IW-1:0] pick_idx,
  output logic          busy,
  output logic [LW-1:0] stack_level,
  output logic          stack_err
);
  import assoc_pkg::*;

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [LW-1:0] LVL_TOP = LW'(DEPTH - 1);

  assoc_op_e     op;
  logic          acc;
  logic          ev_push, ev_ovf, ev_pop, ev_unf, ev_and, ev_pick, ev_clear, ev_mm;
  logic          mm_busy, mm_done;
  logic [N-1:0]  mm_win, pick_oh, top_v, hit_v, wr_bits;
  logic [N*W-1:0] recs_flat;
  logic [LW-1:0] lvl_q, wr_lvl;
  logic          wr_en, err_q;
  logic          any_w;
  logic [IW-1:0] first_w;

  assign op  = assoc_op_e'(op_code);
  assign acc = op_valid && !mm_busy;

  // named events
  assign ev_push  = acc && (op == OP_PUSH) && (lvl_q != LVL_TOP);
  assign ev_ovf   = acc && (op == OP_PUSH) && (lvl_q == LVL_TOP);
  assign ev_pop   = acc && (op == OP_POP)  && (lvl_q != '0);
  assign ev_unf   = acc && (op == OP_POP)  && (lvl_q == '0);
  assign ev_and   = acc && (op == OP_AND);
  assign ev_pick  = acc && (op == OP_PICK);
  assign ev_clear = acc && (op == OP_CLEAR);
  assign ev_mm    = acc && ((op == OP_MIN) || (op == OP_MAX));

  assign wr_en  = ev_push || ev_and || ev_pick || mm_done;
  assign wr_lvl = ev_push ? (lvl_q + LW'(1)) : lvl_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (mm_done)      wr_bits[i] = mm_win[i];
      else if (ev_pick) wr_bits[i] = pick_oh[i];
      else              wr_bits[i] = top_v[i] & hit_v[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pe
      logic [W-1:0] rec_w;
      assoc_pe #(.W(W), .DEPTH(DEPTH), .LW(LW)) u_pe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en && (ld_idx == IW'(g))),
        .ld_data (ld_data),
        .key     (key),
        .fmask   (fmask),
        .clr     (ev_clear),
        .wr_en   (wr_en),
        .wr_lvl  (wr_lvl),
        .wr_bit  (wr_bits[g]),
        .rd_lvl  (lvl_q),
        .rec_o   (rec_w),
        .hit_o   (hit_v[g]),
        .top_o   (top_v[g])
      );
      assign recs_flat[g*W +: W] = rec_w;
    end
  endgenerate

  assoc_resolve #(.N(N), .IW(IW)) u_pick (
    .resp      (top_v),
    .any_o     (any_w),
    .first_idx (first_w),
    .first_oh  (pick_oh)
  );

  assoc_minmax #(.N(N), .W(W), .IW(IW), .BW(BW)) u_mm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_mm),
    .want_max  (op == OP_MAX),
    .fmask     (fmask),
    .seed      (top_v),
    .recs_flat (recs_flat),
    .busy      (mm_busy),
    .done      (mm_done),
    .win_oh    (mm_win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ev_ovf || ev_unf) err_q <= 1'b1;
      if (ev_clear)     lvl_q <= '0;
      else if (ev_push) lvl_q <= lvl_q + LW'(1);
      else if (ev_pop)  lvl_q <= lvl_q - LW'(1);
    end
  end

  assign resp_vec    = top_v;
  assign any_resp    = any_w;
  assign pick_valid  = any_w;
  assign pick_idx    = first_w;
  assign busy        = mm_busy;
  assign stack_level = lvl_q;
  assign stack_err   = err_q;

endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  resp_vec,
  input logic          any_resp,
  input logic          pick_valid,
  input logic [IW-1:0] pick_idx,
  input logic          busy,
  input logic [LW-1:0] stack_level,
  input logic          stack_err,
  input logic          ev_pop,
  input logic          ev_clear,
  input logic          mm_done
);

  p_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_resp |-> (resp_vec == '0));

  p_pick_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> resp_vec[pick_idx]);

  p_pick_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> ((resp_vec & ((N'(1) << pick_idx) - N'(1))) == '0));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_clear |=> ((stack_level == $past(stack_level)) ||
                   (stack_level == $past(stack_level) + LW'(1)) ||
                   (stack_level + LW'(1) == $past(stack_level))));

  p_mm_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mm_done |=> ($countones(resp_vec) <= 1));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(stack_level));

  p_no_revive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_pop || ev_clear) |=> ((resp_vec & ~$past(resp_vec)) == '0));

endmodule

bind assoc_array assoc_array_chk #(.N(N), .IW(IW), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .resp_vec    (resp_vec),
  .any_resp    (any_resp),
  .pick_valid  (pick_valid),
  .pick_idx    (pick_idx),
  .busy        (busy),
  .stack_level (stack_level),
  .stack_err   (stack_err),
  .ev_pop      (ev_pop),
  .ev_clear    (ev_clear),
  .mm_done     (mm_done)
);

// File: tb/assoc_array_bench.sv
module assoc_array_bench;
  localparam int N = 8, W = 4, DEPTH = 4, IW = 3, LW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic [W-1:0]  ld_data;
  logic          op_valid;
  logic [2:0]    op_code;
  logic [W-1:0]  key, fmask;
  logic [N-1:0]  resp_vec;
  logic          any_resp, pick_valid, busy, stack_err;
  logic [IW-1:0] pick_idx;
  logic [LW-1:0] stack_level;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] mrec [N];
  logic [N-1:0] exp_v, lvl1_v;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  assoc_array #(.N(N), .W(W), .DEPTH(DEPTH)) u_assoc_array (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .op_valid(op_valid), .op_code(op_code), .key(key), .fmask(fmask),
    .resp_vec(resp_vec), .any_resp(any_resp), .pick_valid(pick_valid),
    .pick_idx(pick_idx), .busy(busy), .stack_level(stack_level), .stack_err(stack_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [W-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mrec[idx] = v;
  endtask

  task automatic do_op(input logic [2:0] c, input logic [W-1:0] k, input logic [W-1:0] m);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; key = k; fmask = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [N-1:0] hits(input logic [W-1:0] k, input logic [W-1:0] m);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (mrec[i] & m) == (k & m);
    return r;
  endfunction

  function automatic int low_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] extreme(input logic [N-1:0] v, input logic [W-1:0] m,
                                           input bit mx);
    int best = -1;
    int at = -1;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        int val = int'(mrec[i] & m);
        if (best < 0 || (mx ? val > best : val < best)) begin best = val; at = i; end
      end
    end
    return (at < 0) ? '0 : (N'(1) << at);
  endfunction

  task automatic check_resp(input string tag, input logic [N-1:0] e);
    chk({tag, " resp_vec"}, 32'(resp_vec), 32'(e));
    chk({tag, " any_resp"}, 32'(any_resp), 32'(e != '0));
    chk({tag, " pick_valid"}, 32'(pick_valid), 32'(e != '0));
    if (e != '0) chk({tag, " pick_idx"}, 32'(pick_idx), 32'(low_idx(e)));
  endtask

  task automatic run_mm(input bit mx, input logic [W-1:0] m, input logic [N-1:0] seed);
    int cnt = 0;
    do_op(mx ? 3'd5 : 3'd4, '0, m);
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R7 busy cycles", 32'(cnt), 32'(W));
    check_resp("R7 min/max winner", extreme(seed, m, mx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_data = '0;
    op_valid = 1'b0; op_code = '0; key = '0; fmask = '0;
    for (int i = 0; i < N; i++) mrec[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state, R5/R6 resolution on the full set
    chk("R4 level", 32'(stack_level), 0);
    chk("R4 err", 32'(stack_err), 0);
    chk("R4 busy", 32'(busy), 0);
    check_resp("R4 R5 R6 reset", '1);

    for (int i = 0; i < N; i++) load(i, W'((i * 5 + 3) % 16));

    // R1 sweep of key and mask, R5/R6 checked each time
    for (int mi = 0; mi < 4; mi++) begin
      logic [W-1:0] m;
      m = (mi == 0) ? 4'hF : (mi == 1) ? 4'h3 : (mi == 2) ? 4'hC : 4'h0;
      for (int k = 0; k < 16; k++) begin
        do_op(3'd1, W'(k), m);
        chk("R1 level", 32'(stack_level), 1);
        check_resp("R1 search", hits(W'(k), m));
        do_op(3'd3, '0, '0);
        check_resp("R3 pop to base", '1);
      end
    end

    // R2 refine top; R10 a dropped PE stays dropped
    do_op(3'd1, 4'h1, 4'h1);
    exp_v = hits(4'h1, 4'h1);
    do_op(3'd2, 4'h2, 4'h2);
    exp_v = exp_v & hits(4'h2, 4'h2);
    chk("R2 level", 32'(stack_level), 1);
    check_resp("R2 and", exp_v);
    do_op(3'd2, 4'h0, 4'h0);
    check_resp("R10 no revive", exp_v);
    do_op(3'd3, '0, '0);

    // R6 pick narrows
    do_op(3'd1, 4'h0, 4'h1);
    exp_v = hits(4'h0, 4'h1);
    do_op(3'd6, '0, '0);
    check_resp("R6 pick", N'(1) << low_idx(exp_v));
    do_op(3'd3, '0, '0);

    // R3 nested restore, overflow, underflow
    do_op(3'd1, 4'h1, 4'h1);
    lvl1_v = hits(4'h1, 4'h1);
    do_op(3'd1, 4'h0, 4'h8);
    check_resp("R1 nested", lvl1_v & hits(4'h0, 4'h8));
    do_op(3'd3, '0, '0);
    check_resp("R3 pop restores", lvl1_v);
    do_op(3'd1, '0, '0);
    do_op(3'd1, '0, '0);
    chk("R3 level top", 32'(stack_level), 3);
    chk("R3 err before", 32'(stack_err), 0);
    do_op(3'd1, 4'hF, 4'hF);
    chk("R3 overflow err", 32'(stack_err), 1);
    chk("R3 overflow level", 32'(stack_level), 3);
    check_resp("R3 overflow stack", lvl1_v);
    for (int i = 0; i < 3; i++) do_op(3'd3, '0, '0);
    check_resp("R3 back to base", '1);
    do_op(3'd3, '0, '0);
    chk("R3 underflow level", 32'(stack_level), 0);
    chk("R3 underflow err", 32'(stack_err), 1);
    do_op(3'd1, 4'h1, 4'h1);
    do_op(3'd7, '0, '0);
    chk("R4 clear level", 32'(stack_level), 0);
    chk("R4 clear keeps err", 32'(stack_err), 1);
    check_resp("R4 clear stack", '1);

    // R4 reset clears err and records
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) mrec[i] = '0;
    chk("R4 err after reset", 32'(stack_err), 0);
    do_op(3'd1, 4'h0, 4'hF);
    check_resp("R4 records zero", '1);
    do_op(3'd3, '0, '0);

    // R7 sweep over record sets, filters, masks, directions
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < N; i++) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        load(i, W'(lcg >> 16));
      end
      for (int f = 0; f < 2; f++) begin
        for (int mx = 0; mx < 2; mx++) begin
          for (int mi = 0; mi < 3; mi++) begin
            logic [W-1:0] m;
            m = (mi == 0) ? 4'hF : (mi == 1) ? 4'h6 : 4'h9;
            do_op(3'd1, 4'h1, f ? 4'h1 : 4'h0);
            run_mm(mx[0], m, hits(4'h1, f ? 4'h1 : 4'h0));
            do_op(3'd3, '0, '0);
          end
        end
      end
    end

    // R7 empty set stays empty
    do_op(3'd1, mrec[0], 4'hF);
    do_op(3'd2, mrec[0] ^ 4'h1, 4'hF);
    check_resp("R7 empty seed", '0);
    run_mm(1'b0, 4'hF, '0);
    do_op(3'd3, '0, '0);

    // R8 op during reduction ignored
    do_op(3'd1, '0, '0);
    do_op(3'd4, '0, 4'hF);
    do_op(3'd1, '0, '0);
    while (busy) @(negedge clk);
    chk("R8 level unchanged", 32'(stack_level), 1);
    check_resp("R8 result", extreme('1, 4'hF, 1'b0));
    do_op(3'd3, '0, '0);

    // R9 load and search in the same cycle
    do_op(3'd1, '0, '0);
    begin
      logic [W-1:0] nv;
      nv = mrec[2] ^ 4'hF;
      exp_v = hits(nv, 4'hF);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 3'd2; ld_data = nv;
      op_valid = 1'b1; op_code = 3'd2; key = nv; fmask = 4'hF;
      @(negedge clk);
      ld_en = 1'b0; op_valid = 1'b0;
      check_resp("R9 old record seen", exp_v);
      mrec[2] = nv;
      do_op(3'd3, '0, '0);
      do_op(3'd1, nv, 4'hF);
      check_resp("R9 new record seen", hits(nv, 4'hF));
      chk("R9 pe2 responds", 32'(resp_vec[2]), 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule